// File: doc/BRIEF.md
# DMA Single-Transfer Bus Cycle Sequencer

This block carries out one DMA transfer once the CPU has handed over the system bus. After it samples the hold acknowledge input high, it moves through an address cycle, a command cycle, optional wait cycles and a completion cycle. In the address cycle it drives the low address byte on a dedicated port. It also places the high address byte on the shared data port and pulses a strobe so that an external latch can capture that byte. In the command cycle it drives the active-low memory and I/O strobes that match the selected transfer type.

Four transfer types are supported: peripheral-to-memory, memory-to-peripheral, a verify cycle with no strobes, and a memory-to-memory move in two passes. The move first reads a byte into an internal holding register, then writes it to a destination address. The I/O read and write lines are shared with the CPU, so the block enables its drivers for them only while a transfer is running. At completion it steps the address up by one and the word count down by one. It raises a terminal pulse when the count wraps past zero. Addresses and the count can be loaded while the block is idle.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset the block is idle: all four strobes are high, `io_oe`, `db_oe`, `adstb` and `done` are low.
- R2: When `hold_ack` is sampled high in idle, the next cycle is the address cycle. In that cycle `adstb` and `db_oe` are high, `db_out` carries address bits [W-1:8] and `addr_lo` carries bits [7:0]. `addr_lo` holds the current address for the whole transfer.
- R3: `xfer_type` is sampled when idle is left, with this encoding: 2'b01 = write (`ior_n` and `memw_n` low), 2'b10 = read (`memr_n` and `iow_n` low), 2'b00 = verify, 2'b11 = memory-to-memory. The two strobes of a transfer go low together, starting in the cycle after the address cycle.
- R4: Each cycle in which `ready` is sampled low while a strobe is active lengthens the strobe by one clock. With N consecutive low samples, the strobe is low for N+1 cycles.
- R5: In verify mode no strobe goes low and `ready` is ignored. The transfer is active for exactly three cycles.
- R6: In a memory-to-memory move, pass one drives `memr_n` low at the source address. It captures `db_in` in the last strobe cycle, which is the cycle in which `ready` is high. Pass two follows directly at the destination address: it drives `memw_n` low and, in every strobe cycle, holds `db_oe` high with the captured byte on `db_out`. The I/O strobes stay high in both passes.
- R7: `io_oe` is high exactly while a transfer is active and low in idle.
- R8: In the completion cycle the address used steps up by one. After a single transfer or the second pass of a move, the count steps down by one. `done` is high in that completion cycle only when the count was zero, and the count then wraps to all ones.
- R9: The load strobes `ld_src`, `ld_dst` and `ld_cnt` take `ld_val` only while idle. During a transfer they have no effect.
- R10: After completion the block returns to idle. It needs `hold_ack` high again before it starts another transfer. The second pass of a move does not need it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_ack | input | 1 | Bus granted, sampled on the clock |
| xfer_type | input | 2 | Transfer type, sampled when idle is left |
| ready | input | 1 | Low inserts a wait cycle |
| ld_src | input | 1 | Load source address from `ld_val` (idle only) |
| ld_dst | input | 1 | Load destination address from `ld_val` (idle only) |
| ld_cnt | input | 1 | Load word count from `ld_val` (idle only) |
| ld_val | input | W | Load value |
| db_in | input | 8 | Data port input |
| db_out | output | 8 | Data port output |
| db_oe | output | 1 | Data port output enable |
| addr_lo | output | 8 | Low address byte |
| adstb | output | 1 | High address byte latch strobe |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| io_oe | output | 1 | Output enable for the I/O strobes |
| done | output | 1 | Count wrapped in this completion cycle |

## Verification
The bench targets these corner cases:
- Wait cycles inserted back to back. A design that counted them wrongly would leave a strobe one clock short or long.
- A verify transfer with `ready` held low. A design that honoured `ready` there would hang in waits or pulse a strobe.
- A memory-to-memory move where `db_in` changes every clock. Latching it one cycle early or late writes the wrong byte in the second pass.
- Loads attempted mid-transfer, which a faulty design would let move the address.
- Runs that reach a zero count, where `done` must fire exactly once.

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_ack,
  input  logic [1:0]   xfer_type,
  input  logic         ready,
  input  logic         ld_src,
  input  logic         ld_dst,
  input  logic         ld_cnt,
  input  logic [W-1:0] ld_val,
  input  logic [7:0]   db_in,
  output logic [7:0]   db_out,
  output logic         db_oe,
  output logic [7:0]   addr_lo,
  output logic         adstb,
  output logic         memr_n,
  output logic         memw_n,
  output logic         ior_n,
  output logic         iow_n,
  output logic         io_oe,
  output logic         done
);
  localparam logic [1:0] XT_VER = 2'b00, XT_WR = 2'b01, XT_RD = 2'b10, XT_MM = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WAIT, S_DONE} st_t;
  st_t st;

  logic [W-1:0] src_q, dst_q, cnt_q;
  logic [1:0]   mode;
  logic         pass;
  logic [7:0]   tmp;

  wire          mm     = (mode == XT_MM);
  wire          strobe = (st == S_CMD || st == S_WAIT) && mode != XT_VER;
  wire [W-1:0]  cur    = (mm && pass) ? dst_q : src_q;
  wire          last   = mm ? pass : 1'b1;

  assign memr_n  = !(strobe && (mode == XT_RD || (mm && !pass)));
  assign memw_n  = !(strobe && (mode == XT_WR || (mm && pass)));
  assign ior_n   = !(strobe && mode == XT_WR);
  assign iow_n   = !(strobe && mode == XT_RD);
  assign io_oe   = (st != S_IDLE);
  assign adstb   = (st == S_ADDR);
  assign db_oe   = adstb || (strobe && mm && pass);
  assign db_out  = adstb ? cur[W-1:8] : tmp;
  assign addr_lo = cur[7:0];
  assign done    = (st == S_DONE) && last && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      mode  <= XT_VER;
      pass  <= 1'b0;
      tmp   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (ld_src) src_q <= ld_val;
          if (ld_dst) dst_q <= ld_val;
          if (ld_cnt) cnt_q <= ld_val;
          if (hold_ack) begin
            st   <= S_ADDR;
            mode <= xfer_type;
            pass <= 1'b0;
          end
        end
        S_ADDR: st <= S_CMD;
        S_CMD, S_WAIT: begin
          if (mode == XT_VER) st <= S_DONE;
          else if (!ready)    st <= S_WAIT;
          else begin
            if (mm && !pass) tmp <= db_in;
            st <= S_DONE;
          end
        end
        S_DONE: begin
          if (mm && pass) dst_q <= dst_q + 1'b1;
          else            src_q <= src_q + 1'b1;
          if (last) begin
            cnt_q <= cnt_q - 1'b1;
            st    <= S_IDLE;
            pass  <= 1'b0;
          end else begin
            pass <= 1'b1;
            st   <= S_ADDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  idle_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && hold_ack) |=> (adstb && db_oe));
  // R3
  pair_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (!iow_n) |-> (!memr_n && memw_n && ior_n));
  // R3
  pair_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (!ior_n) |-> (!memw_n && memr_n && iow_n));
  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && !ready) |=> ($stable(memr_n) && $stable(memw_n) && $stable(ior_n) && $stable(iow_n)));
  // R5
  verify_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_CMD && mode == XT_VER) |-> (memr_n && memw_n && ior_n && iow_n) ##1 (st == S_DONE));
  // R7
  io_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (!ior_n || !iow_n) |-> io_oe);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  return_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_DONE && last) |=> !io_oe);
endmodule

// File: tb/dma_xfer_seq_bench.sv
module dma_xfer_seq_bench;
  localparam int W = 16;
  logic clk = 0, rst = 1;
  logic hold_ack = 0, ready = 1, ld_src = 0, ld_dst = 0, ld_cnt = 0;
  logic [1:0] xfer_type = 0;
  logic [W-1:0] ld_val = 0;
  logic [7:0] db_in = 8'h5a;
  logic [7:0] db_out, addr_lo;
  logic db_oe, adstb, memr_n, memw_n, ior_n, iow_n, io_oe, done;

  always #2 clk = ~clk;

  dma_xfer_seq #(.W(W)) u_dma_xfer_seq (
    .clk(clk), .rst(rst), .hold_ack(hold_ack), .xfer_type(xfer_type), .ready(ready),
    .ld_src(ld_src), .ld_dst(ld_dst), .ld_cnt(ld_cnt), .ld_val(ld_val), .db_in(db_in),
    .db_out(db_out), .db_oe(db_oe), .addr_lo(addr_lo), .adstb(adstb), .memr_n(memr_n),
    .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n), .io_oe(io_oe), .done(done));

  int checks = 0, fails = 0, cycles = 0;
  int low_cnt = 0, act_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 address, 2 command, 3 wait, 4 completion
  int m_st = 0, m_mode = 0, m_pass = 0, m_tmp = 0;
  int m_src = 0, m_dst = 0, m_cnt = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_st = 0; m_src = 0; m_dst = 0; m_cnt = 0; m_mode = 0; m_pass = 0; m_tmp = 0;
    end else begin
      case (m_st)
        0: begin
          if (ld_src) m_src = ld_val;
          if (ld_dst) m_dst = ld_val;
          if (ld_cnt) m_cnt = ld_val;
          if (hold_ack) begin m_st = 1; m_mode = xfer_type; m_pass = 0; end
        end
        1: m_st = 2;
        2, 3: begin
          if (m_mode == 0) m_st = 4;
          else if (!ready) m_st = 3;
          else begin
            if (m_mode == 3 && m_pass == 0) m_tmp = db_in;
            m_st = 4;
          end
        end
        default: begin
          if (m_mode == 3 && m_pass == 0) begin
            m_src = (m_src + 1) % 65536; m_pass = 1; m_st = 1;
          end else begin
            if (m_mode == 3) m_dst = (m_dst + 1) % 65536;
            else m_src = (m_src + 1) % 65536;
            m_cnt = (m_cnt + 65535) % 65536;
            m_st = 0; m_pass = 0;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      bit stb;
      int cur;
      bit e_done;
      stb = (m_st == 2 || m_st == 3) && m_mode != 0;
      cur = (m_mode == 3 && m_pass == 1) ? m_dst : m_src;
      e_done = (m_st == 4) && m_cnt == 0 && (m_mode != 3 || m_pass == 1);
      chk(memr_n == !(stb && (m_mode == 2 || (m_mode == 3 && m_pass == 0))), "R3 memr_n", memr_n, 0);
      chk(memw_n == !(stb && (m_mode == 1 || (m_mode == 3 && m_pass == 1))), "R3 memw_n", memw_n, 0);
      chk(ior_n == !(stb && m_mode == 1), "R3 ior_n", ior_n, !(stb && m_mode == 1));
      chk(iow_n == !(stb && m_mode == 2), "R3 iow_n", iow_n, !(stb && m_mode == 2));
      chk(io_oe == (m_st != 0), "R7 R10 io_oe", io_oe, m_st != 0);
      chk(adstb == (m_st == 1), "R2 adstb", adstb, m_st == 1);
      chk(db_oe == (m_st == 1 || (stb && m_mode == 3 && m_pass == 1)), "R2 R6 db_oe", db_oe, 0);
      if (m_st == 1) chk(db_out == cur[15:8], "R2 db_out high byte", db_out, cur[15:8]);
      if (stb && m_mode == 3 && m_pass == 1) chk(db_out == m_tmp[7:0], "R6 db_out moved byte", db_out, m_tmp[7:0]);
      if (m_st != 0) chk(addr_lo == cur[7:0], "R2 R8 R9 addr_lo", addr_lo, cur[7:0]);
      chk(done == e_done, "R8 done", done, e_done);
      if (!iow_n || !ior_n) low_cnt++;
      if (io_oe) act_cnt++;
    end
    db_in <= db_in * 8'd5 + 8'd3;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int src, input int dst, input int cnt);
    ld_src = 1; ld_val = src[W-1:0]; step(1); ld_src = 0;
    ld_dst = 1; ld_val = dst[W-1:0]; step(1); ld_dst = 0;
    ld_cnt = 1; ld_val = cnt[W-1:0]; step(1); ld_cnt = 0;
  endtask

  task automatic xfer(input logic [1:0] t, input int waits);
    xfer_type = t; hold_ack = 1; step(1);
    hold_ack = 0; step(1);
    ready = 0; step(waits); ready = 1;
    step(12);
  endtask

  initial begin
    step(3);
    chk(memr_n && memw_n && ior_n && iow_n, "R1 strobes high", {memr_n, memw_n, ior_n, iow_n}, 4'hf);
    chk(!io_oe && !db_oe && !adstb && !done, "R1 enables low", {io_oe, db_oe, adstb, done}, 0);
    rst = 0;
    step(4);
    chk(!io_oe, "R10 stays idle without hold_ack", io_oe, 0);
    load(16'h12f0, 16'h8000, 3);
    xfer(2'b01, 0);
    low_cnt = 0; xfer(2'b10, 2);
    chk(low_cnt == 3, "R4 strobe length with two waits", low_cnt, 3);
    act_cnt = 0; xfer(2'b00, 5);
    chk(act_cnt == 3, "R5 verify ignores ready", act_cnt, 3);
    xfer(2'b11, 1);
    xfer(2'b11, 0);
    // R9: loads attempted mid-transfer
    xfer_type = 2'b01; hold_ack = 1; step(1); hold_ack = 0;
    ld_src = 1; ld_cnt = 1; ld_val = 16'h4444; step(3); ld_src = 0; ld_cnt = 0;
    step(6);
    load(16'h00ff, 16'hfffe, 0);
    xfer(2'b10, 1);
    xfer(2'b11, 3);
    step(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule